// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block shapes the second operand of an integer execution stage before it reaches the ALU. It takes a 32-bit operand and applies one of four shifts to it: logical left, logical right, arithmetic right or rotate right. It also produces the carry-out of the shift, which the flag logic downstream may use. The amount of the shift comes from one of two places, chosen by a select input. One source is a small immediate field in the instruction. The other is the value of a general register.

The two amount sources do not agree on every value. An immediate amount of zero is a special code. For the right shifts it means a full-width shift. For rotate it means a single-bit rotate that passes through the carry flag. A register amount is taken from the low byte of the register. Zero leaves the operand untouched, and values of 32 and above saturate, each with its own carry rule.

The result and the carry-out are captured in registers on the rising clock edge. The outputs therefore show the shift of the inputs presented one cycle earlier.

Top module: `operand_shifter`

## Requirements
- R1: A synchronous active-high reset clears the result and the carry-out to zero. Outside reset, the outputs show the shift of the inputs sampled on the previous rising edge.
- R2: The shift type input uses these codes: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right. The amount select is 1 for the register source and 0 for the immediate source. For logical left by n in 1..31 from either source, the result is the operand shifted left by n and the carry-out is operand bit 32-n.
- R3: For logical right, arithmetic right and rotate right by n in 1..31 from either source, the result is the shifted or rotated operand. Arithmetic right fills with bit 31. The carry-out is operand bit n-1.
- R4: An immediate logical-left amount of zero, or a register amount of zero for any shift type, passes the operand through unchanged and copies the incoming carry to the carry-out.
- R5: An immediate amount of zero with logical right gives result 0 and carry bit 31. An immediate amount of zero with arithmetic right fills all 32 bits with bit 31 and gives carry bit 31.
- R6: An immediate amount of zero with rotate right gives {carry in, operand[31:1]} and carry-out operand bit 0.
- R7: For the register source, only bits 7:0 of the register form the amount. Bits 31:8 have no effect on the outputs.
- R8: A register amount of exactly 32 gives result 0 for both logical shifts. The carry is bit 31 for logical right and bit 0 for logical left.
- R9: A register amount above 32 gives result 0 and carry 0 for both logical shifts.
- R10: A register amount of 32 or more with arithmetic right fills all bits with bit 31 and gives carry bit 31.
- R11: A register rotate uses the amount modulo 32. A nonzero multiple of 32 leaves the operand unchanged and gives carry bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| operand_i | input | 32 | Operand to be shifted |
| shift_op_i | input | 2 | Shift type code (see R2) |
| amt_from_reg_i | input | 1 | 1 selects the register amount, 0 the immediate |
| imm_amt_i | input | 5 | Immediate shift amount |
| reg_amt_i | input | 32 | Register value supplying the amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Registered shifted operand |
| carry_o | output | 1 | Registered shifter carry-out |

## Verification
In every cycle, the logarithmic shift network and the special-amount override both act on the same operand. When an override applies, the network still computes a shift from the low five amount bits, and that shift is discarded. The bench provokes this conflict with register amounts whose low five bits look like an ordinary amount, such as 36, 64, 0x120 and 0xFFFFFF04. It then judges whether saturation, wrap or byte truncation wins over the network's output. A second overlap is the incoming carry: it is both the guard seed of the network and the fill bit of the one-bit rotate. This is exercised by toggling the carry flag across zero-amount and rotate cases and comparing against values computed in the bench.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_op_e;

  // How the decoded amount is to be applied to the operand
  typedef enum logic [2:0] {
    AK_PASS = 3'd0,  // no movement, carry from flag
    AK_CORE = 3'd1,  // ordinary shift by 1..width-1
    AK_FULL = 3'd2,  // full-width shift (or arithmetic saturation)
    AK_OVER = 3'd3,  // logical shift beyond full width
    AK_RRX  = 3'd4,  // one-bit rotate through carry
    AK_WRAP = 3'd5   // rotate by nonzero multiple of width
  } amt_kind_e;

endpackage

// File: rtl/sr_amount_decode.sv
module sr_amount_decode
  import shifter_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8,
  localparam int SH_W     = $clog2(DATA_W)
) (
  input  shift_op_e            op,
  input  logic                 from_reg,
  input  logic [SH_W-1:0]      imm_amt,
  input  logic [REG_AMT_W-1:0] reg_byte,
  output amt_kind_e            kind,
  output logic [SH_W-1:0]      core_amt
);

  localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);

  logic byte_low_zero;
  assign byte_low_zero = (reg_byte[SH_W-1:0] == '0);

  always_comb begin
    kind     = AK_CORE;
    core_amt = '0;
    if (from_reg) begin
      core_amt = reg_byte[SH_W-1:0];
      if (reg_byte == '0) begin
        kind = AK_PASS;
      end else if (op == SH_ROR) begin
        kind = byte_low_zero ? AK_WRAP : AK_CORE;
      end else if (reg_byte < FULL_AMT) begin
        kind = AK_CORE;
      end else if (reg_byte == FULL_AMT || op == SH_ASR) begin
        kind = AK_FULL;
      end else begin
        kind = AK_OVER;
      end
    end else begin
      core_amt = imm_amt;
      if (imm_amt == '0) begin
        unique case (op)
          SH_LSL:  kind = AK_PASS;
          SH_ROR:  kind = AK_RRX;
          default: kind = AK_FULL;
        endcase
      end
    end
  end

endmodule

// File: rtl/sr_shift_core.sv
module sr_shift_core #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_in,
  input  logic [SH_W-1:0]   amt,
  input  logic              fill_bit,
  input  logic              rotate,
  input  logic              guard_in,
  output logic [DATA_W-1:0] data_out,
  output logic              guard_out
);

  // Right-moving logarithmic network; the guard bit records the last bit
  // pushed out of the bottom, which becomes the shifter carry.
  logic [DATA_W-1:0] stage_d [SH_W+1];
  logic              stage_g [SH_W+1];

  assign stage_d[0] = data_in;
  assign stage_g[0] = guard_in;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [STEP-1:0] top_fill;
    assign top_fill = rotate ? stage_d[k][STEP-1:0] : {STEP{fill_bit}};
    assign stage_d[k+1] = amt[k] ? {top_fill, stage_d[k][DATA_W-1:STEP]}
                                 : stage_d[k];
    assign stage_g[k+1] = amt[k] ? stage_d[k][STEP-1] : stage_g[k];
  end

  assign data_out  = stage_d[SH_W];
  assign guard_out = stage_g[SH_W];

endmodule

// File: rtl/sr_result_select.sv
module sr_result_select
  import shifter_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  amt_kind_e         kind,
  input  shift_op_e         op,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] core_res,
  input  logic              core_carry,
  output logic [DATA_W-1:0] res,
  output logic              carry
);

  logic msb;
  assign msb = operand[DATA_W-1];

  always_comb begin
    res   = core_res;
    carry = core_carry;
    unique case (kind)
      AK_PASS: begin
        res   = operand;
        carry = carry_in;
      end
      AK_FULL: begin
        res   = (op == SH_ASR) ? {DATA_W{msb}} : '0;
        carry = (op == SH_LSL) ? operand[0] : msb;
      end
      AK_OVER: begin
        res   = '0;
        carry = 1'b0;
      end
      AK_RRX: begin
        res   = {carry_in, operand[DATA_W-1:1]};
        carry = operand[0];
      end
      AK_WRAP: begin
        res   = operand;
        carry = msb;
      end
      default: begin
        res   = core_res;
        carry = core_carry;
      end
    endcase
  end

endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import shifter_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8,
  localparam int SH_W     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [1:0]        shift_op_i,
  input  logic              amt_from_reg_i,
  input  logic [SH_W-1:0]   imm_amt_i,
  input  logic [DATA_W-1:0] reg_amt_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);

  localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);

  shift_op_e op;
  assign op = shift_op_e'(shift_op_i);

  // Register bits above the amount byte take no part in the shift
  logic [DATA_W-REG_AMT_W-1:0] amt_hi_unused;
  assign amt_hi_unused = reg_amt_i[DATA_W-1:REG_AMT_W];

  amt_kind_e       kind;
  logic [SH_W-1:0] core_amt;

  sr_amount_decode #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)) u_decode (
    .op       (op),
    .from_reg (amt_from_reg_i),
    .imm_amt  (imm_amt_i),
    .reg_byte (reg_amt_i[REG_AMT_W-1:0]),
    .kind     (kind),
    .core_amt (core_amt)
  );

  // Left shifts run through the right-moving core on a mirrored operand
  logic [DATA_W-1:0] mirror_in, mirror_out, core_in, core_out, core_res;
  for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
    assign mirror_in[i]  = operand_i[DATA_W-1-i];
    assign mirror_out[i] = core_out[DATA_W-1-i];
  end

  logic is_left, core_carry;
  assign is_left = (op == SH_LSL);
  assign core_in = is_left ? mirror_in : operand_i;

  sr_shift_core #(.DATA_W(DATA_W)) u_core (
    .data_in   (core_in),
    .amt       (core_amt),
    .fill_bit  ((op == SH_ASR) & operand_i[DATA_W-1]),
    .rotate    (op == SH_ROR),
    .guard_in  (carry_i),
    .data_out  (core_out),
    .guard_out (core_carry)
  );

  assign core_res = is_left ? mirror_out : core_out;

  logic [DATA_W-1:0] next_res;
  logic              next_carry;

  sr_result_select #(.DATA_W(DATA_W)) u_select (
    .kind       (kind),
    .op         (op),
    .operand    (operand_i),
    .carry_in   (carry_i),
    .core_res   (core_res),
    .core_carry (core_carry),
    .res        (next_res),
    .carry      (next_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= 1'b0;
    end else begin
      result_o <= next_res;
      carry_o  <= next_carry;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (result_o == '0 && !carry_o)); // R1

  AST_REG_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
    (amt_from_reg_i && reg_amt_i[REG_AMT_W-1:0] == '0)
    |=> (result_o == $past(operand_i) && carry_o == $past(carry_i))); // R4

  AST_IMM_LSR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!amt_from_reg_i && imm_amt_i == '0 && shift_op_i == 2'b01)
    |=> (result_o == '0 && carry_o == $past(operand_i[DATA_W-1]))); // R5

  AST_IMM_RRX: assert property (@(posedge clk) disable iff (rst)
    (!amt_from_reg_i && imm_amt_i == '0 && shift_op_i == 2'b11)
    |=> (result_o == {$past(carry_i), $past(operand_i[DATA_W-1:1])}
         && carry_o == $past(operand_i[0]))); // R6

  AST_LOGIC_OVER: assert property (@(posedge clk) disable iff (rst)
    (amt_from_reg_i && reg_amt_i[REG_AMT_W-1:0] > FULL_AMT && !shift_op_i[1])
    |=> (result_o == '0 && !carry_o)); // R9

  AST_ASR_SAT: assert property (@(posedge clk) disable iff (rst)
    (amt_from_reg_i && reg_amt_i[REG_AMT_W-1:0] >= FULL_AMT && shift_op_i == 2'b10)
    |=> (result_o == {DATA_W{$past(operand_i[DATA_W-1])}}
         && carry_o == $past(operand_i[DATA_W-1]))); // R10

endmodule

// File: tb/operand_shifter_test.sv
module operand_shifter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] operand_i = '0;
  logic [1:0]  shift_op_i = '0;
  logic        amt_from_reg_i = 1'b0;
  logic [4:0]  imm_amt_i = '0;
  logic [31:0] reg_amt_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  operand_shifter uut (
    .clk(clk), .rst(rst), .operand_i(operand_i), .shift_op_i(shift_op_i),
    .amt_from_reg_i(amt_from_reg_i), .imm_amt_i(imm_amt_i),
    .reg_amt_i(reg_amt_i), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o)
  );

  localparam logic [1:0] LSL = 2'b00, LSR = 2'b01, ASR = 2'b10, ROR = 2'b11;

  // Expected {carry, result} derived from the requirement text
  function automatic logic [32:0] model(logic [1:0] op, logic src, logic [4:0] imm,
                                        logic [31:0] ramt, logic [31:0] x, logic c);
    int n;
    logic [63:0] w;
    logic [31:0] r;
    n = src ? int'(ramt[7:0]) : int'(imm);
    if (n == 0) begin
      if (src || op == LSL) return {c, x};
      if (op == ROR) return {x[0], c, x[31:1]};
      n = 32;
    end
    case (op)
      LSL: begin
        if (n > 32) return 33'd0;
        w = {32'd0, x} << n;
        return {w[32], w[31:0]};
      end
      LSR: begin
        if (n > 32) return 33'd0;
        w = {x, 32'd0} >> n;
        return {w[31], w[63:32]};
      end
      ASR: begin
        if (n >= 32) return {x[31], {32{x[31]}}};
        w = $signed({x, 32'd0}) >>> n;
        return {w[31], w[63:32]};
      end
      default: begin
        n = n % 32;
        if (n == 0) return {x[31], x};
        r = (x >> n) | (x << (32 - n));
        return {r[31], r};
      end
    endcase
  endfunction

  task automatic check(string req, logic [31:0] exp_r, logic exp_c);
    checks++;
    if (result_o !== exp_r || carry_o !== exp_c) begin
      failures++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
               req, result_o, carry_o, exp_r, exp_c);
    end
  endtask

  // Drive at a falling edge, let one rising edge capture, check at next fall
  task automatic run(string req, logic [1:0] op, logic src, logic [4:0] imm,
                     logic [31:0] ramt, logic [31:0] x, logic c,
                     logic [31:0] exp_r, logic exp_c);
    @(negedge clk);
    shift_op_i = op; amt_from_reg_i = src; imm_amt_i = imm;
    reg_amt_i = ramt; operand_i = x; carry_i = c;
    @(negedge clk);
    check(req, exp_r, exp_c);
  endtask

  task automatic run_model(string req, logic [1:0] op, logic src, logic [4:0] imm,
                           logic [31:0] ramt, logic [31:0] x, logic c);
    logic [32:0] e;
    e = model(op, src, imm, ramt, x, c);
    run(req, op, src, imm, ramt, x, c, e[31:0], e[32]);
  endtask

  task automatic t_reset_and_latency();
    @(negedge clk);
    check("R1 reset", 32'h0, 1'b0);
    rst = 1'b0;
    run("R1", LSR, 1'b0, 5'd4, 32'h0, 32'hF0000000, 1'b0, 32'h0F000000, 1'b0);
    @(negedge clk);
    operand_i = 32'h00000080;
    #1 check("R1 hold before edge", 32'h0F000000, 1'b0);
    @(negedge clk);
    check("R1 after edge", 32'h00000008, 1'b0);
  endtask

  task automatic t_left_normal();
    run("R2 imm", LSL, 1'b0, 5'd1, 32'h0, 32'h80000001, 1'b0, 32'h00000002, 1'b1);
    run("R2 reg", LSL, 1'b1, 5'd0, 32'd31, 32'h00000003, 1'b1, 32'h80000000, 1'b1);
    run("R2 imm8", LSL, 1'b0, 5'd8, 32'h0, 32'h12345678, 1'b1, 32'h34567800, 1'b0);
  endtask

  task automatic t_right_normal();
    run("R3 lsr", LSR, 1'b1, 5'd0, 32'd1, 32'h00000003, 1'b0, 32'h00000001, 1'b1);
    run("R3 asr", ASR, 1'b0, 5'd4, 32'h0, 32'h8000_0018, 1'b0, 32'hF800_0001, 1'b1);
    run("R3 ror", ROR, 1'b0, 5'd8, 32'h0, 32'h1234_56F8, 1'b0, 32'hF812_3456, 1'b1);
    run("R3 asr31", ASR, 1'b1, 5'd0, 32'd31, 32'h4000_0000, 1'b1, 32'h0, 1'b1);
  endtask

  task automatic t_zero_pass();
    run("R4 imm lsl0", LSL, 1'b0, 5'd0, 32'h0, 32'hDEADBEEF, 1'b1, 32'hDEADBEEF, 1'b1);
    run("R4 reg0 ror", ROR, 1'b1, 5'd7, 32'h0, 32'hA5A5A5A5, 1'b0, 32'hA5A5A5A5, 1'b0);
    run("R4 reg0 asr", ASR, 1'b1, 5'd3, 32'h0, 32'h80000001, 1'b1, 32'h80000001, 1'b1);
  endtask

  task automatic t_imm_zero();
    run("R5 lsr0", LSR, 1'b0, 5'd0, 32'h0, 32'h80000000, 1'b0, 32'h0, 1'b1);
    run("R5 asr0", ASR, 1'b0, 5'd0, 32'h0, 32'h80000000, 1'b0, 32'hFFFFFFFF, 1'b1);
    run("R5 asr0 pos", ASR, 1'b0, 5'd0, 32'h0, 32'h7FFFFFFF, 1'b1, 32'h0, 1'b0);
    run("R6 rrx c1", ROR, 1'b0, 5'd0, 32'h0, 32'h00000003, 1'b1, 32'h80000001, 1'b1);
    run("R6 rrx c0", ROR, 1'b0, 5'd0, 32'h0, 32'h80000002, 1'b0, 32'h40000001, 1'b0);
  endtask

  task automatic t_byte_only();
    run("R7 hi bits", LSR, 1'b1, 5'd0, 32'hFFFFFF04, 32'h000000F8, 1'b0, 32'h0000000F, 1'b1);
    run("R7 hi zero", LSL, 1'b1, 5'd0, 32'h00000100, 32'h12345678, 1'b1, 32'h12345678, 1'b1);
    run("R7 0x120", LSR, 1'b1, 5'd0, 32'h00000120, 32'h80000000, 1'b0, 32'h0, 1'b1);
  endtask

  task automatic t_reg_full();
    run("R8 lsr32", LSR, 1'b1, 5'd0, 32'd32, 32'h80000000, 1'b0, 32'h0, 1'b1);
    run("R8 lsl32", LSL, 1'b1, 5'd0, 32'd32, 32'h00000001, 1'b0, 32'h0, 1'b1);
    run("R8 lsl32 b0", LSL, 1'b1, 5'd0, 32'd32, 32'hFFFFFFFE, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_reg_over();
    run("R9 lsl33", LSL, 1'b1, 5'd0, 32'd33, 32'hFFFFFFFF, 1'b1, 32'h0, 1'b0);
    run("R9 lsr36", LSR, 1'b1, 5'd0, 32'd36, 32'hFFFFFFFF, 1'b1, 32'h0, 1'b0);
    run("R9 lsr255", LSR, 1'b1, 5'd0, 32'd255, 32'hFFFFFFFF, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_asr_sat();
    run("R10 asr32", ASR, 1'b1, 5'd0, 32'd32, 32'h80000000, 1'b0, 32'hFFFFFFFF, 1'b1);
    run("R10 asr200", ASR, 1'b1, 5'd0, 32'd200, 32'h7FFFFFFF, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_reg_rotate();
    run("R11 ror36", ROR, 1'b1, 5'd0, 32'd36, 32'h0000001F, 1'b0, 32'hF0000001, 1'b1);
    run("R11 ror64", ROR, 1'b1, 5'd0, 32'd64, 32'h80000001, 1'b0, 32'h80000001, 1'b1);
    run("R11 ror32", ROR, 1'b1, 5'd0, 32'd32, 32'h7FFFFFFF, 1'b1, 32'h7FFFFFFF, 1'b0);
  endtask

  task automatic t_sweep();
    logic [31:0] s;
    s = 32'h1357_9BDF;
    for (int i = 0; i < 200; i++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      run_model((s[0] ? "R2 sweep" : "R3 sweep"), s[2:1], s[3], s[8:4],
                {s[31:24], 16'h0, (s[9] ? s[17:10] : {3'b0, s[14:10]})},
                s ^ {s[15:0], s[31:16]}, s[20]);
    end
  endtask

  initial begin
    t_reset_and_latency();
    t_left_normal();
    t_right_normal();
    t_zero_pass();
    t_imm_zero();
    t_byte_only();
    t_reg_full();
    t_reg_over();
    t_asr_sat();
    t_reg_rotate();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule